// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Register Block

This block sits next to a SECDED decoder on a 64-bit memory data path (eight check bits cover each 8-byte word). The decoder sends one-cycle pulses: one for a correctable error, which carries an 8-bit syndrome, and one for an uncorrectable error. Each pulse also carries the failing address and the 64-bit data word. The block copies these details into one of two capture register sets, one set for each error class. It then flags the event in an interrupt status register. Software clears the flags by writing ones back to an acknowledge register.

The block also holds an option register. This register selects the ECC mode and can arm a one-shot fault injection. While injection is armed, an 8-bit pattern is offered for XOR into the check bits of the next memory write. Injection disarms itself once that write has happened.

Access goes through a simple register port. It has two windows, a control window and an interrupt window, each addressed by a 6-bit byte offset. Reads are combinational and writes take effect on the clock edge.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset, interrupt status reads 0, `irq` is 0, every capture register reads 0, and the option register reads the mode reset value (default 1) with injection disarmed.
- R2: When a correctable pulse arrives while status bit 3 is clear, status bit 3 (0x08) is set. The correctable set captures the event: address at control offset 0x18, syndrome in bits [15:8] of 0x1C, data bits [31:0] at 0x20 and data bits [63:32] at 0x24.
- R3: When a correctable pulse arrives while status bit 3 is already set, status bit 4 (0x10) is set and the correctable capture registers keep their earlier contents.
- R4: When an uncorrectable pulse arrives while status bit 5 is clear, status bit 5 (0x20) is set. The uncorrectable set captures the event: address at 0x08, syndrome in bits [15:8] of 0x0C, data low at 0x10 and data high at 0x14.
- R5: When an uncorrectable pulse arrives while status bit 5 is already set, status bit 6 (0x40) is set and the uncorrectable capture registers are left unchanged.
- R6: Interrupt status is read at interrupt-window offset 0x00, with bits [6:3] meaningful. A write to interrupt-window offset 0x04 clears each status bit whose position is 1 in the written value and leaves the other bits as they were.
- R7: If an error pulse and an acknowledge of the same status bit fall in the same cycle, the bit stays set.
- R8: `irq` is a registered level equal to the OR of status bits 3 to 6 as they stood one clock earlier.
- R9: The option register sits at control offset 0x00 and holds the mode in [1:0], the arm bit in [8] and the XOR pattern in [23:16]. Other bits read 0. `ecc_active` is 1 for modes 1 and 3 and 0 for modes 0 and 2.
- R10: While the arm bit is set, `inj_xor` presents the pattern; otherwise it is 0. A memory write (`wr_fire`) clears the arm bit and keeps the mode and the pattern.
- R11: Once a class's first-error bit has been acknowledged, the next pulse of that class reloads its capture set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_win | input | 1 | Window select: 0 control/capture, 1 interrupt |
| bus_addr | input | 6 | Byte offset within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ce_evt | input | 1 | Correctable error pulse |
| ue_evt | input | 1 | Uncorrectable error pulse |
| evt_syn | input | 8 | Syndrome for the pulse |
| evt_addr | input | ADDR_W | Failing address |
| evt_data | input | 64 | Data word of the failing read |
| wr_fire | input | 1 | A memory write is using the check bits this cycle |
| inj_xor | output | 8 | Pattern to XOR into the check bits |
| ecc_active | output | 1 | ECC is enabled by the current mode |
| irq | output | 1 | Interrupt level |

## Verification
Each class is driven first with a single pulse and then with a second pulse that carries a different address and syndrome. This separates a correct first capture from a capture that is wrongly overwritten. Acknowledge writes use partial masks and then a full mask, which shows clearing bit by bit instead of clearing everything. A pulse and an acknowledge land in the same cycle to settle which one wins, and a pulse after clearing confirms that capture is re-armed. Option writes step through all four modes and put an armed pattern across two memory writes, which shows that injection affects exactly one write.

// File: rtl/ecc_err_regs.sv
module ecc_err_regs #(
  parameter int         ADDR_W   = 32,
  parameter logic [1:0] MODE_RST = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_win,
  input  logic [5:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [7:0]        evt_syn,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [63:0]       evt_data,
  input  logic              wr_fire,
  output logic [7:0]        inj_xor,
  output logic              ecc_active,
  output logic              irq
);
  localparam logic [5:0] OFS_OPT   = 6'h00;
  localparam logic [5:0] OFS_U_ADR = 6'h08;
  localparam logic [5:0] OFS_U_STA = 6'h0C;
  localparam logic [5:0] OFS_U_DLO = 6'h10;
  localparam logic [5:0] OFS_U_DHI = 6'h14;
  localparam logic [5:0] OFS_C_ADR = 6'h18;
  localparam logic [5:0] OFS_C_STA = 6'h1C;
  localparam logic [5:0] OFS_C_DLO = 6'h20;
  localparam logic [5:0] OFS_C_DHI = 6'h24;
  localparam logic [5:0] OFS_ISTAT = 6'h00;
  localparam logic [5:0] OFS_IACK  = 6'h04;

  logic [1:0]        mode;
  logic              arm;
  logic [7:0]        pat;
  logic [6:3]        st, st_n, ack_m;
  logic [ADDR_W-1:0] c_adr, u_adr;
  logic [7:0]        c_syn, u_syn;
  logic [63:0]       c_dat, u_dat;
  logic              unused_wbits;

  wire opt_wr = bus_we && !bus_win && bus_addr == OFS_OPT;
  wire ack_wr = bus_we &&  bus_win && bus_addr == OFS_IACK;
  wire c_load = ce_evt && !st[3];
  wire u_load = ue_evt && !st[5];

  assign ack_m        = ack_wr ? bus_wdata[6:3] : 4'b0;
  assign unused_wbits = ^{bus_wdata[31:24], bus_wdata[15:9], bus_wdata[7:2]};

  assign st_n[3] = ce_evt | (st[3] & ~ack_m[3]);
  assign st_n[4] = (ce_evt & st[3]) | (st[4] & ~ack_m[4]);
  assign st_n[5] = ue_evt | (st[5] & ~ack_m[5]);
  assign st_n[6] = (ue_evt & st[5]) | (st[6] & ~ack_m[6]);

  assign inj_xor    = arm ? pat : 8'h00;
  assign ecc_active = mode[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= '0;
      irq <= 1'b0;
    end else begin
      st  <= st_n;
      irq <= |st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_RST;
      arm  <= 1'b0;
      pat  <= '0;
    end else if (opt_wr) begin
      mode <= bus_wdata[1:0];
      arm  <= bus_wdata[8];
      pat  <= bus_wdata[23:16];
    end else if (wr_fire) begin
      arm  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_adr <= '0; c_syn <= '0; c_dat <= '0;
      u_adr <= '0; u_syn <= '0; u_dat <= '0;
    end else begin
      if (c_load) begin
        c_adr <= evt_addr; c_syn <= evt_syn; c_dat <= evt_data;
      end
      if (u_load) begin
        u_adr <= evt_addr; u_syn <= evt_syn; u_dat <= evt_data;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_win) begin
      if (bus_addr == OFS_ISTAT) bus_rdata[6:3] = st;
    end else begin
      case (bus_addr)
        OFS_OPT:   bus_rdata = {8'h00, pat, 7'h00, arm, 6'h00, mode};
        OFS_U_ADR: bus_rdata = 32'(u_adr);
        OFS_U_STA: bus_rdata = {16'h0000, u_syn, 8'h00};
        OFS_U_DLO: bus_rdata = u_dat[31:0];
        OFS_U_DHI: bus_rdata = u_dat[63:32];
        OFS_C_ADR: bus_rdata = 32'(c_adr);
        OFS_C_STA: bus_rdata = {16'h0000, c_syn, 8'h00};
        OFS_C_DLO: bus_rdata = c_dat[31:0];
        OFS_C_DHI: bus_rdata = c_dat[63:32];
        default:   bus_rdata = '0;
      endcase
    end
  end

  p_ce_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt && !st[3] |=> st[3] && c_syn == $past(evt_syn) && c_adr == $past(evt_addr));
  p_ce_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt && st[3] |=> st[4] && c_dat == $past(c_dat) && c_syn == $past(c_syn));
  p_ue_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt && !st[5] |=> st[5] && u_dat == $past(evt_data));
  p_ue_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt && st[5] |=> st[6] && u_adr == $past(u_adr));
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && bus_wdata[6] && !(ue_evt && st[5]) |=> !st[6]);
  p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && bus_wdata[3] && ce_evt |=> st[3]);
  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|st));
  p_arm_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arm && wr_fire && !opt_wr |=> !arm && $stable(mode) && $stable(pat));
endmodule

// File: tb/tb_ecc_err_regs.sv
`timescale 1ns/1ps
module tb_ecc_err_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_win = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        ce_evt = 1'b0, ue_evt = 1'b0, wr_fire = 1'b0;
  logic [7:0]  evt_syn = '0, inj_xor;
  logic [31:0] evt_addr = '0;
  logic [63:0] evt_data = '0;
  logic        ecc_active, irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  ecc_err_regs dut (.clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ce_evt(ce_evt),
    .ue_evt(ue_evt), .evt_syn(evt_syn), .evt_addr(evt_addr), .evt_data(evt_data),
    .wr_fire(wr_fire), .inj_xor(inj_xor), .ecc_active(ecc_active), .irq(irq));

  // monitor: kind 0 rdata, 1 irq, 2 inj_xor, 3 ecc_active
  always begin
    @(negedge clk);
    #5;
    if (q_kind.size() > 0) begin
      automatic int k = q_kind.pop_front();
      automatic logic [31:0] e = q_exp.pop_front();
      automatic string t = q_tag.pop_front();
      automatic logic [31:0] a = (k == 0) ? bus_rdata : (k == 1) ? 32'(irq) :
                                 (k == 2) ? 32'(inj_xor) : 32'(ecc_active);
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic quiet();
    bus_we = 1'b0; ce_evt = 1'b0; ue_evt = 1'b0; wr_fire = 1'b0;
  endtask

  task automatic rd(input logic w, input logic [5:0] a, input logic [31:0] e, input string t);
    @(negedge clk); quiet();
    bus_win = w; bus_addr = a;
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic sig(input int k, input logic [31:0] e, input string t);
    @(negedge clk); quiet();
    q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic wr(input logic w, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); quiet();
    bus_win = w; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
  endtask

  task automatic pulse(input logic ce, input logic ue, input logic [7:0] s,
                       input logic [31:0] ad, input logic [63:0] d);
    @(negedge clk); quiet();
    ce_evt = ce; ue_evt = ue; evt_syn = s; evt_addr = ad; evt_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(0, 6'h00, 32'h1, "R1 option");
    rd(1, 6'h00, 32'h0, "R1 status");
    rd(0, 6'h18, 32'h0, "R1 ce addr");
    rd(0, 6'h10, 32'h0, "R1 ue data lo");
    sig(1, 0, "R1 irq");
    sig(2, 0, "R1 inj_xor");

    pulse(1, 0, 8'h5A, 32'h1000_0040, 64'hDEAD_BEEF_0123_4567);
    sig(1, 0, "R8 irq lags one cycle");
    sig(1, 1, "R8 irq raised");
    rd(1, 6'h00, 32'h08, "R2 status");
    rd(0, 6'h18, 32'h1000_0040, "R2 ce addr");
    rd(0, 6'h1C, 32'h5A00, "R2 ce syndrome");
    rd(0, 6'h20, 32'h0123_4567, "R2 ce data lo");
    rd(0, 6'h24, 32'hDEAD_BEEF, "R2 ce data hi");

    pulse(1, 0, 8'h11, 32'h1000_0FF8, 64'h1111_2222_3333_4444);
    rd(1, 6'h00, 32'h18, "R3 status");
    rd(0, 6'h18, 32'h1000_0040, "R3 ce addr kept");
    rd(0, 6'h1C, 32'h5A00, "R3 ce syndrome kept");
    rd(0, 6'h20, 32'h0123_4567, "R3 ce data kept");

    pulse(0, 1, 8'h33, 32'h2000_0080, 64'h0F0F_0F0F_F0F0_F0F0);
    rd(1, 6'h00, 32'h38, "R4 status");
    rd(0, 6'h08, 32'h2000_0080, "R4 ue addr");
    rd(0, 6'h0C, 32'h3300, "R4 ue syndrome");
    rd(0, 6'h10, 32'hF0F0_F0F0, "R4 ue data lo");
    rd(0, 6'h14, 32'h0F0F_0F0F, "R4 ue data hi");

    pulse(0, 1, 8'h77, 32'h2000_1000, 64'h0);
    rd(1, 6'h00, 32'h78, "R5 status");
    rd(0, 6'h08, 32'h2000_0080, "R5 ue addr kept");
    rd(0, 6'h14, 32'h0F0F_0F0F, "R5 ue data kept");

    wr(1, 6'h04, 32'h10);
    rd(1, 6'h00, 32'h68, "R6 partial ack");
    rd(1, 6'h04, 32'h0, "R6 ack reads 0");
    wr(1, 6'h04, 32'h68);
    sig(1, 1, "R8 irq still high one cycle");
    sig(1, 0, "R8 irq low after clear");
    rd(1, 6'h00, 32'h0, "R6 full ack");

    pulse(1, 0, 8'hC3, 32'h3000_0000, 64'hAAAA_5555_AAAA_5555);
    rd(0, 6'h18, 32'h3000_0000, "R11 ce addr reloaded");
    rd(0, 6'h1C, 32'hC300, "R11 ce syndrome reloaded");

    @(negedge clk); quiet();
    ce_evt = 1'b1; evt_addr = 32'h3000_0100; evt_syn = 8'h01;
    bus_win = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h08; bus_we = 1'b1;
    rd(1, 6'h00, 32'h18, "R7 event beats ack");
    rd(0, 6'h18, 32'h3000_0000, "R7 capture kept");
    wr(1, 6'h04, 32'h7F);
    rd(1, 6'h00, 32'h0, "R6 clear all");

    wr(0, 6'h00, 32'h00AB_0103);
    rd(0, 6'h00, 32'h00AB_0103, "R9 option readback");
    sig(2, 32'hAB, "R10 armed pattern");
    sig(2, 32'hAB, "R10 pattern held until write");
    sig(3, 1, "R9 mode 3 active");
    @(negedge clk); quiet(); wr_fire = 1'b1;
    sig(2, 0, "R10 disarmed after write");
    rd(0, 6'h00, 32'h00AB_0003, "R10 mode and pattern kept");
    @(negedge clk); quiet(); wr_fire = 1'b1;
    sig(2, 0, "R10 second write not injected");

    wr(0, 6'h00, 32'h2);
    sig(3, 0, "R9 mode 2 inactive");
    wr(0, 6'h00, 32'h0);
    sig(3, 0, "R9 mode 0 inactive");
    wr(0, 6'h00, 32'h1);
    sig(3, 1, "R9 mode 1 active");
    wr(0, 6'h00, 32'hFFFF_FFFF);
    rd(0, 6'h00, 32'h00FF_0103, "R9 reserved bits read 0");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule